// File: doc/BRIEF.md
# Synchronous Dual-Port Burst RAM

This block is a two-port synchronous static RAM. Either port can read or write any word of a shared array in any cycle, independently of the other. Each port samples its select, write flag, address, write data and burst controls on the rising clock edge. Each port also has its own burst address counter, so a stream of consecutive words can be moved after a single address is given. The counter can be loaded, cleared to zero or stepped upward, and it wraps from the top of the array back to zero.

A static latency input chooses the read path for both ports. Flow-through mode presents read data one cycle sooner. Pipelined mode adds one output register stage. A port that has been deselected for a cycle is powered down. In pipelined mode it then needs one selected cycle to wake before it accepts an access. Both ports run from one shared clock, so a collision on one address in one cycle has a single defined outcome.

Top module: `dpr_core`

## Requirements
- R1: The two ports work independently in the same cycle: a read on one port and a write on the other, at different addresses, both take effect.
- R2: With `flow_mode`=1 (flow-through), read data and `x_rvalid`=1 appear after the second rising edge that follows the cycle in which the request was driven. With `flow_mode`=0 (pipelined), they appear after the third.
- R3: A read registered one cycle after a write to the same address returns the newly written word.
- R4: When `x_clr_n`=1 and `x_ld_n`=0, the port's counter loads `x_addr`, and the access in that cycle uses the loaded address.
- R5: When `x_clr_n`=0, the counter becomes zero for that access, whatever `x_ld_n` and `x_cnt_n` are (highest priority).
- R6: When `x_clr_n`=1, `x_ld_n`=1 and `x_cnt_n`=0, the counter steps by one on each edge. From DEPTH-1 it steps to 0.
- R7: With all three counter controls high, the counter keeps its value and `x_addr` is ignored.
- R8: When both ports write one address in the same cycle, port A's word is stored. A read that meets a write from the other port on the same address in the same cycle returns the old word.
- R9: After a write cycle or a deselected cycle, `x_rvalid` is 0 and `x_rdata` keeps the last word read.
- R10: After a cycle with `x_sel`=0, the next selected cycle in pipelined mode is a wake cycle: it performs no write and produces no `x_rvalid`. In flow-through mode that cycle is a normal access.
- R11: Reset (`rst`=1, synchronous, active high) clears `x_rvalid`, `x_rdata` and both counters to zero, and leaves both ports powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst | input | 1 | Synchronous active-high reset |
| flow_mode | input | 1 | 1 = flow-through read path, 0 = pipelined (static) |
| a_sel | input | 1 | Port A select, active high |
| a_wr | input | 1 | Port A: 1 = write, 0 = read |
| a_addr | input | AW | Port A external address |
| a_wdata | input | DW | Port A write data |
| a_clr_n | input | 1 | Port A counter clear, active low |
| a_ld_n | input | 1 | Port A counter load, active low |
| a_cnt_n | input | 1 | Port A counter step, active low |
| a_rdata | output | DW | Port A read data |
| a_rvalid | output | 1 | Port A read data valid |
| b_sel | input | 1 | Port B select, active high |
| b_wr | input | 1 | Port B: 1 = write, 0 = read |
| b_addr | input | AW | Port B external address |
| b_wdata | input | DW | Port B write data |
| b_clr_n | input | 1 | Port B counter clear, active low |
| b_ld_n | input | 1 | Port B counter load, active low |
| b_cnt_n | input | 1 | Port B counter step, active low |
| b_rdata | output | DW | Port B read data |
| b_rvalid | output | 1 | Port B read data valid |

## Verification
The case where both ports reach the same word in one cycle is the one that needs care. The bench provokes it by driving two writes to one address in the same cycle, and by pairing a write on port A with a read of that address on port B. Each outcome is judged by what port B returns: the collided read must show the word held before that cycle, and later reads must show port A's word where both ports wrote. Clear, load and step requests on one port's counter are also presented together, and the bench confirms that clear takes priority.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    localparam int NPORTS = 2;

    typedef enum logic [1:0] {
        CTR_HOLD  = 2'd0,
        CTR_INC   = 2'd1,
        CTR_LOAD  = 2'd2,
        CTR_CLEAR = 2'd3
    } ctr_op_e;

    typedef enum logic {
        LAT_PIPE = 1'b0,
        LAT_FLOW = 1'b1
    } lat_mode_e;

    typedef struct packed {
        logic sel;
        logic wr;
    } acc_req_t;

    // Clear outranks load, load outranks step; all controls active low.
    function automatic ctr_op_e ctr_decode(input logic clr_n, input logic ld_n,
                                           input logic cnt_n);
        if (!clr_n)      return CTR_CLEAR;
        else if (!ld_n)  return CTR_LOAD;
        else if (!cnt_n) return CTR_INC;
        return CTR_HOLD;
    endfunction

    // A selected port may act unless it is waking from power-down in pipelined mode.
    function automatic logic may_access(input logic sel, input logic asleep,
                                        input lat_mode_e mode);
        return sel && ((mode == LAT_FLOW) || !asleep);
    endfunction

endpackage

// File: rtl/dpr_burst_ctr.sv
module dpr_burst_ctr
    import dpr_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  ctr_op_e       op,
    input  logic [AW-1:0] ld_addr,
    output logic [AW-1:0] addr_q
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0] addr_d;

    always_comb begin
        unique case (op)
            CTR_CLEAR: addr_d = '0;
            CTR_LOAD:  addr_d = ld_addr;
            CTR_INC:   addr_d = (addr_q == LAST) ? '0 : addr_q + 1'b1;
            default:   addr_d = addr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) addr_q <= '0;
        else     addr_q <= addr_d;
    end

endmodule

// File: rtl/dpr_port_front.sv
module dpr_port_front
    import dpr_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 36,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  lat_mode_e     mode,
    input  logic          sel,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          clr_n,
    input  logic          ld_n,
    input  logic          cnt_n,
    output logic          acc_rd,
    output logic          acc_wr,
    output logic [AW-1:0] acc_addr,
    output logic [DW-1:0] acc_wdata
);

    acc_req_t      req_q;
    logic          asleep_q;
    logic [DW-1:0] wdata_q;
    ctr_op_e       op;
    logic          go;

    assign op = ctr_decode(clr_n, ld_n, cnt_n);

    // The counter register doubles as the registered access address.
    dpr_burst_ctr #(.DEPTH(DEPTH), .AW(AW)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .ld_addr (addr),
        .addr_q  (acc_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q    <= '0;
            wdata_q  <= '0;
            asleep_q <= 1'b1;
        end else begin
            req_q    <= '{sel: sel, wr: wr};
            wdata_q  <= wdata;
            asleep_q <= !req_q.sel;
        end
    end

    assign go        = may_access(req_q.sel, asleep_q, mode);
    assign acc_wr    = go && req_q.wr;
    assign acc_rd    = go && !req_q.wr;
    assign acc_wdata = wdata_q;

endmodule

// File: rtl/dpr_read_stage.sv
module dpr_read_stage
    import dpr_pkg::*;
#(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst,
    input  lat_mode_e     mode,
    input  logic          rd_en,
    input  logic [DW-1:0] rd_word,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);

    logic [DW-1:0] near_q;
    logic [DW-1:0] far_q;
    logic          near_v;
    logic          far_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            near_q <= '0;
            far_q  <= '0;
            near_v <= 1'b0;
            far_v  <= 1'b0;
        end else begin
            near_v <= rd_en;
            far_v  <= near_v;
            if (rd_en)  near_q <= rd_word;
            if (near_v) far_q  <= near_q;
        end
    end

    assign rdata  = (mode == LAT_FLOW) ? near_q : far_q;
    assign rvalid = (mode == LAT_FLOW) ? near_v : far_v;

endmodule

// File: rtl/dpr_core.sv
module dpr_core
    import dpr_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 36,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flow_mode,
    input  logic          a_sel,
    input  logic          a_wr,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    input  logic          a_clr_n,
    input  logic          a_ld_n,
    input  logic          a_cnt_n,
    output logic [DW-1:0] a_rdata,
    output logic          a_rvalid,
    input  logic          b_sel,
    input  logic          b_wr,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    input  logic          b_clr_n,
    input  logic          b_ld_n,
    input  logic          b_cnt_n,
    output logic [DW-1:0] b_rdata,
    output logic          b_rvalid
);

    lat_mode_e     mode;
    logic [DW-1:0] mem [DEPTH];

    logic          p_sel   [NPORTS];
    logic          p_wr    [NPORTS];
    logic [AW-1:0] p_addr  [NPORTS];
    logic [DW-1:0] p_wdata [NPORTS];
    logic          p_clr_n [NPORTS];
    logic          p_ld_n  [NPORTS];
    logic          p_cnt_n [NPORTS];

    logic          acc_rd    [NPORTS];
    logic          acc_wr    [NPORTS];
    logic [AW-1:0] acc_addr  [NPORTS];
    logic [DW-1:0] acc_wdata [NPORTS];
    logic [DW-1:0] rd_word   [NPORTS];
    logic [DW-1:0] p_rdata   [NPORTS];
    logic          p_rvalid  [NPORTS];

    assign mode = lat_mode_e'(flow_mode);

    assign p_sel[0]   = a_sel;    assign p_sel[1]   = b_sel;
    assign p_wr[0]    = a_wr;     assign p_wr[1]    = b_wr;
    assign p_addr[0]  = a_addr;   assign p_addr[1]  = b_addr;
    assign p_wdata[0] = a_wdata;  assign p_wdata[1] = b_wdata;
    assign p_clr_n[0] = a_clr_n;  assign p_clr_n[1] = b_clr_n;
    assign p_ld_n[0]  = a_ld_n;   assign p_ld_n[1]  = b_ld_n;
    assign p_cnt_n[0] = a_cnt_n;  assign p_cnt_n[1] = b_cnt_n;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        dpr_port_front #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_front (
            .clk       (clk),
            .rst       (rst),
            .mode      (mode),
            .sel       (p_sel[p]),
            .wr        (p_wr[p]),
            .addr      (p_addr[p]),
            .wdata     (p_wdata[p]),
            .clr_n     (p_clr_n[p]),
            .ld_n      (p_ld_n[p]),
            .cnt_n     (p_cnt_n[p]),
            .acc_rd    (acc_rd[p]),
            .acc_wr    (acc_wr[p]),
            .acc_addr  (acc_addr[p]),
            .acc_wdata (acc_wdata[p])
        );

        assign rd_word[p] = mem[acc_addr[p]];

        dpr_read_stage #(.DW(DW)) u_rd (
            .clk     (clk),
            .rst     (rst),
            .mode    (mode),
            .rd_en   (acc_rd[p]),
            .rd_word (rd_word[p]),
            .rdata   (p_rdata[p]),
            .rvalid  (p_rvalid[p])
        );
    end

    // Highest port index is applied first, so port 0 (A) lands last and wins.
    always_ff @(posedge clk) begin
        for (int p = NPORTS - 1; p >= 0; p--) begin
            if (acc_wr[p]) mem[acc_addr[p]] <= acc_wdata[p];
        end
    end

    assign a_rdata  = p_rdata[0];
    assign a_rvalid = p_rvalid[0];
    assign b_rdata  = p_rdata[1];
    assign b_rvalid = p_rvalid[1];

endmodule

// File: rtl/dpr_core_chk.sv
module dpr_core_chk #(
    parameter int DEPTH = 64,
    parameter int DW    = 36,
    parameter int AW    = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst,
    input logic          flow_mode,
    input logic [AW-1:0] a_addr,
    input logic          a_clr_n,
    input logic          a_ld_n,
    input logic          a_cnt_n,
    input logic [DW-1:0] a_rdata,
    input logic          a_rvalid,
    input logic [AW-1:0] b_addr,
    input logic          b_clr_n,
    input logic          b_ld_n,
    input logic          b_cnt_n,
    input logic [DW-1:0] b_rdata,
    input logic          b_rvalid,
    input logic [AW-1:0] ctr_a,
    input logic [AW-1:0] ctr_b
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    AST_CLR_TO_ZERO_A: assert property (@(posedge clk) disable iff (rst)
        !a_clr_n |=> (ctr_a == '0)); // R5
    AST_CLR_TO_ZERO_B: assert property (@(posedge clk) disable iff (rst)
        !b_clr_n |=> (ctr_b == '0)); // R5
    AST_LOAD_A: assert property (@(posedge clk) disable iff (rst)
        (a_clr_n && !a_ld_n) |=> (ctr_a == $past(a_addr))); // R4
    AST_LOAD_B: assert property (@(posedge clk) disable iff (rst)
        (b_clr_n && !b_ld_n) |=> (ctr_b == $past(b_addr))); // R4
    AST_STEP_WRAP_A: assert property (@(posedge clk) disable iff (rst)
        (a_clr_n && a_ld_n && !a_cnt_n) |=>
        (ctr_a == (($past(ctr_a) == LAST) ? '0 : $past(ctr_a) + 1'b1))); // R6
    AST_HOLD_A: assert property (@(posedge clk) disable iff (rst)
        (a_clr_n && a_ld_n && a_cnt_n) |=> $stable(ctr_a)); // R7
    AST_HOLD_B: assert property (@(posedge clk) disable iff (rst)
        (b_clr_n && b_ld_n && b_cnt_n) |=> $stable(ctr_b)); // R7
    AST_RDATA_KEEP_A: assert property (@(posedge clk) disable iff (rst)
        ($stable(flow_mode) && !a_rvalid) |-> $stable(a_rdata)); // R9
    AST_RDATA_KEEP_B: assert property (@(posedge clk) disable iff (rst)
        ($stable(flow_mode) && !b_rvalid) |-> $stable(b_rdata)); // R9

endmodule

bind dpr_core dpr_core_chk #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .flow_mode (flow_mode),
    .a_addr    (a_addr),
    .a_clr_n   (a_clr_n),
    .a_ld_n    (a_ld_n),
    .a_cnt_n   (a_cnt_n),
    .a_rdata   (a_rdata),
    .a_rvalid  (a_rvalid),
    .b_addr    (b_addr),
    .b_clr_n   (b_clr_n),
    .b_ld_n    (b_ld_n),
    .b_cnt_n   (b_cnt_n),
    .b_rdata   (b_rdata),
    .b_rvalid  (b_rvalid),
    .ctr_a     (acc_addr[0]),
    .ctr_b     (acc_addr[1])
);

// File: tb/dpr_core_tb_top.sv
module dpr_core_tb_top;

    localparam int DEPTH = 64;
    localparam int DW    = 36;
    localparam int AW    = 6;
    localparam int NT    = 8;

    localparam logic [2:0] IDLE = 3'b111;
    localparam logic [2:0] LD   = 3'b101;
    localparam logic [2:0] CNT  = 3'b110;

    // {wr, addr[5:0], data[7:0], expect_valid, expect_data[7:0]}
    localparam logic [23:0] TBL [NT] = '{
        {1'b1, 6'd3,  8'h11, 1'b0, 8'h00},
        {1'b1, 6'd10, 8'h22, 1'b0, 8'h00},
        {1'b0, 6'd3,  8'h00, 1'b1, 8'h11},
        {1'b1, 6'd63, 8'h33, 1'b0, 8'h00},
        {1'b0, 6'd10, 8'h00, 1'b1, 8'h22},
        {1'b0, 6'd63, 8'h00, 1'b1, 8'h33},
        {1'b1, 6'd3,  8'h44, 1'b0, 8'h00},
        {1'b0, 6'd3,  8'h00, 1'b1, 8'h44}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          flow_mode;
    logic          a_sel, a_wr, a_clr_n, a_ld_n, a_cnt_n;
    logic [AW-1:0] a_addr;
    logic [DW-1:0] a_wdata;
    logic [DW-1:0] a_rdata;
    logic          a_rvalid;
    logic          b_sel, b_wr, b_clr_n, b_ld_n, b_cnt_n;
    logic [AW-1:0] b_addr;
    logic [DW-1:0] b_wdata;
    logic [DW-1:0] b_rdata;
    logic          b_rvalid;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    dpr_core #(.DEPTH(DEPTH), .DW(DW)) dut_i (
        .clk(clk), .rst(rst), .flow_mode(flow_mode),
        .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_clr_n(a_clr_n), .a_ld_n(a_ld_n), .a_cnt_n(a_cnt_n),
        .a_rdata(a_rdata), .a_rvalid(a_rvalid),
        .b_sel(b_sel), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_clr_n(b_clr_n), .b_ld_n(b_ld_n), .b_cnt_n(b_cnt_n),
        .b_rdata(b_rdata), .b_rvalid(b_rvalid)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drv_a(input logic sel, input logic wr, input logic [2:0] ctl,
                         input logic [AW-1:0] addr, input logic [DW-1:0] d);
        a_sel = sel; a_wr = wr; {a_clr_n, a_ld_n, a_cnt_n} = ctl;
        a_addr = addr; a_wdata = d;
    endtask

    task automatic drv_b(input logic sel, input logic wr, input logic [2:0] ctl,
                         input logic [AW-1:0] addr, input logic [DW-1:0] d);
        b_sel = sel; b_wr = wr; {b_clr_n, b_ld_n, b_cnt_n} = ctl;
        b_addr = addr; b_wdata = d;
    endtask

    task automatic run_table(input int lat, input string req);
        for (int i = 0; i < NT + lat; i++) begin
            if (i >= lat) begin
                check(req, "table rvalid", 64'(a_rvalid), 64'(TBL[i-lat][8]));
                if (TBL[i-lat][8])
                    check("R3", "table rdata", 64'(a_rdata), 64'(TBL[i-lat][7:0]));
            end
            if (i < NT)
                drv_a(1'b1, TBL[i][23], LD, TBL[i][22:17], DW'(TBL[i][16:9]));
            else
                drv_a(1'b0, 1'b0, IDLE, '0, '0);
            step();
        end
    endtask

    // Port B burst read: {clr_n, ld_n, cnt_n}, address, expected word
    localparam logic [2:0]  BCTL [9] = '{LD, CNT, CNT, CNT, CNT, CNT, 3'b000, IDLE, LD};
    localparam logic [5:0]  BADR [9] = '{6'd60, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd9, 6'd9, 6'd62};
    localparam logic [11:0] BEXP [9] = '{12'h060, 12'h061, 12'h062, 12'h063, 12'h100,
                                          12'h101, 12'h100, 12'h100, 12'h062};

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        flow_mode = 1'b0;
        drv_a(1'b0, 1'b0, IDLE, '0, '0);
        drv_b(1'b0, 1'b0, IDLE, '0, '0);
        repeat (3) step();
        rst = 1'b0;

        // R11: reset state
        check("R11", "a_rvalid after reset", 64'(a_rvalid), 64'd0);
        check("R11", "a_rdata after reset", 64'(a_rdata), 64'd0);
        check("R11", "b_rvalid after reset", 64'(b_rvalid), 64'd0);
        check("R11", "b_rdata after reset", 64'(b_rdata), 64'd0);

        // R11: port starts powered down, first pipelined read is a wake cycle
        drv_a(1'b1, 1'b0, LD, 6'd5, '0);
        step();
        drv_a(1'b0, 1'b0, IDLE, '0, '0);
        step(); step();
        check("R11", "first read after reset is wake", 64'(a_rvalid), 64'd0);

        // Table in flow-through, then pipelined (R2, R3)
        flow_mode = 1'b1;
        step(); step();
        run_table(2, "R2");
        flow_mode = 1'b0;
        step(); step(); step();
        drv_a(1'b1, 1'b0, IDLE, '0, '0);
        step();
        run_table(3, "R2");

        // Directed tests in flow-through
        flow_mode = 1'b1;
        drv_a(1'b0, 1'b0, IDLE, '0, '0);
        step(); step(); step();

        drv_a(1'b1, 1'b1, LD, 6'd30, 36'h12);
        step();
        // Port A write burst: 60, 61, 62, 63, wrap to 0, then 1 (R6)
        drv_a(1'b1, 1'b1, LD, 6'd60, 36'h60);  step();
        drv_a(1'b1, 1'b1, CNT, 6'd7, 36'h61);  step();
        drv_a(1'b1, 1'b1, CNT, 6'd7, 36'h62);  step();
        drv_a(1'b1, 1'b1, CNT, 6'd7, 36'h63);  step();
        drv_a(1'b1, 1'b1, CNT, 6'd7, 36'h100); step();
        drv_a(1'b1, 1'b1, CNT, 6'd7, 36'h101); step();
        drv_a(1'b0, 1'b0, IDLE, '0, '0);
        step(); step();

        // Port B burst read with clear, hold and reload (R4 R5 R6 R7)
        for (int i = 0; i < 11; i++) begin
            if (i >= 2) begin
                string tag;
                tag = (i - 2 == 6) ? "R5" : (i - 2 == 7) ? "R7" :
                      (i - 2 == 0 || i - 2 == 8) ? "R4" : "R6";
                check(tag, "burst rvalid", 64'(b_rvalid), 64'd1);
                check(tag, "burst rdata", 64'(b_rdata), 64'(BEXP[i-2]));
            end
            if (i < 9) drv_b(1'b1, 1'b0, BCTL[i], BADR[i], '0);
            else       drv_b(1'b0, 1'b0, IDLE, '0, '0);
            step();
        end

        // Collisions (R8) and independent same-cycle access (R1)
        drv_a(1'b1, 1'b1, LD, 6'd21, 36'h55); step();
        drv_a(1'b1, 1'b1, LD, 6'd20, 36'hAA);
        drv_b(1'b1, 1'b1, LD, 6'd20, 36'hBB); step();
        drv_a(1'b1, 1'b1, LD, 6'd21, 36'hCC);
        drv_b(1'b1, 1'b0, LD, 6'd21, '0);     step();
        drv_a(1'b1, 1'b0, LD, 6'd60, '0);
        drv_b(1'b1, 1'b1, LD, 6'd40, 36'h40); step();
        check("R8", "read meets write returns old", 64'(b_rdata), 64'h55);
        drv_a(1'b0, 1'b0, IDLE, '0, '0);
        drv_b(1'b1, 1'b0, LD, 6'd20, '0);     step();
        check("R1", "port A read beside port B write", 64'(a_rdata), 64'h60);
        drv_b(1'b1, 1'b0, LD, 6'd21, '0);     step();
        check("R8", "double write keeps port A word", 64'(b_rdata), 64'hAA);
        drv_b(1'b1, 1'b0, LD, 6'd40, '0);     step();
        check("R3", "later read sees port A write", 64'(b_rdata), 64'hCC);
        drv_b(1'b1, 1'b1, LD, 6'd41, 36'h99); step();
        check("R1", "port B write beside port A read", 64'(b_rdata), 64'h40);
        drv_b(1'b0, 1'b0, IDLE, '0, '0);      step();
        check("R9", "write cycle rvalid", 64'(b_rvalid), 64'd0);
        check("R9", "write cycle rdata held", 64'(b_rdata), 64'h40);
        step();
        check("R9", "deselect rvalid", 64'(b_rvalid), 64'd0);
        check("R9", "deselect rdata held", 64'(b_rdata), 64'h40);

        // Power-down wake in pipelined mode (R10)
        flow_mode = 1'b0;
        step(); step(); step(); step();
        drv_a(1'b1, 1'b0, LD, 6'd30, '0);     step();
        drv_a(1'b0, 1'b0, IDLE, '0, '0);      step();
        drv_a(1'b1, 1'b1, LD, 6'd30, 36'h77); step();
        check("R10", "wake read gives no rvalid", 64'(a_rvalid), 64'd0);
        drv_a(1'b1, 1'b0, LD, 6'd30, '0);     step();
        drv_a(1'b0, 1'b0, IDLE, '0, '0);
        step(); step();
        check("R10", "read after wake rvalid", 64'(a_rvalid), 64'd1);
        check("R10", "wake write ignored", 64'(a_rdata), 64'h12);

        // Flow-through: no wake cycle (R10)
        flow_mode = 1'b1;
        step(); step(); step();
        drv_a(1'b1, 1'b0, LD, 6'd30, '0);     step();
        drv_a(1'b0, 1'b0, IDLE, '0, '0);      step();
        check("R10", "flow read right after deselect rvalid", 64'(a_rvalid), 64'd1);
        check("R10", "flow read right after deselect rdata", 64'(a_rdata), 64'h12);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule